// File: doc/BRIEF.md
# Bus-Attached Serial Port With Programmable Bit Period

This block connects a processor bus to an asynchronous serial line. Software reaches it through two 32-bit word registers. The bit-period register at offset 4 holds the number of system clocks per serial bit. Software loads it with the clock frequency divided by the wanted baud rate. The data register at offset 8 works in both directions. A write queues one byte for transmission. A read returns the byte most recently captured from the line.

Frames have one low start bit, eight data bits least significant bit first, and one high stop bit. Both lines idle high. The receiver has a single byte of storage. A read that returns a byte also frees that storage. When nothing is held, a read of the data register returns all ones, so software can poll without a separate status register. The bus has no wait on reads. A write to the data register is stalled by holding ready low while a frame is still going out.

Top module: `uart_mm`

## Requirements
- R1: After reset the serial output is high, the bit-period register reads 16, and a read of the data register returns 0xFFFFFFFF.
- R2: The bit-period register is at byte address 4 (decoded on the full address). It stores the 32-bit write value, and reads return that value.
- R3: A write to byte address 8 transmits bits [7:0] of the write data as one frame. The frame is 0, then the data bits from bit 0 to bit 7, then 1. Each bit is held for one bit period. The start bit appears on the cycle after the write is accepted.
- R4: When no frame is in progress, the serial output is high.
- R5: A write to the data register while a frame is being sent keeps ready low. Ready returns in the first cycle after the last bit period of the frame ends. Reads and bit-period accesses are always ready in the cycle they are presented.
- R6: When a received byte is held, a data read returns it zero-extended in bits [7:0] and frees the storage.
- R7: When no received byte is held, a data read returns 0xFFFFFFFF.
- R8: The serial input passes through two flip-flops. A frame starts on a high-to-low transition. The start level is checked again after half a bit period. The data bits are then sampled one bit period apart.
- R9: A frame whose stop-bit sample is low is dropped, and the storage keeps its previous state.
- R10: A new good frame overwrites a byte that has not been read.
- R11: A low pulse that has ended before the half-bit check is not taken as a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access request |
| busWe | input | 1 | 1 for write, 0 for read |
| busAddr | input | ADDR_W | Byte address within the block |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, valid while busSel is high |
| busReady | output | 1 | Access completes at the next rising edge |
| rxIn | input | 1 | Serial receive line |
| txOut | output | 1 | Serial transmit line |

## Verification
The cycle-level properties are checked by assertions on every cycle:
- A start strobe never meets a busy transmitter, and the line goes low on the next cycle.
- A stalled data write never sees ready.
- A freed buffer is empty in the next cycle.
- The held byte only ever appears after a high stop sample.
- The bit-period register takes the written value.

The content of each frame, the exact stall length, zero-extension of the data read, dropping of bad frames, overwrite order, and rejection of short glitches depend on whole serial sequences. Only the bench scenarios show these.

// File: rtl/uart_mm_pkg.sv
package uart_mm_pkg;

  // Strobes sent from the bus control to the datapath
  typedef struct packed {
    logic divWe;    // load bit-period register
    logic txStart;  // start a frame with the low byte of write data
    logic rxTake;   // a read consumed the held byte
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rxState_e;

endpackage

// File: rtl/uart_mm_ctrl.sv
module uart_mm_ctrl
  import uart_mm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] divValue,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              rxValid,
  input  logic              txBusy,
  output logic              busReady,
  output logic [DATA_W-1:0] busRdata,
  output ctrlStrobes_t      strobes
);

  localparam logic [ADDR_W-1:0] DIV_OFS  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] DATA_OFS = ADDR_W'(8);

  logic hitDiv;
  logic hitData;
  logic writeStall;

  assign hitDiv     = busSel && (busAddr == DIV_OFS);
  assign hitData    = busSel && (busAddr == DATA_OFS);
  assign writeStall = hitData && busWe && txBusy;

  assign busReady = busSel && !writeStall;

  always_comb begin
    strobes         = '0;
    strobes.divWe   = hitDiv && busWe;
    strobes.txStart = hitData && busWe && !txBusy;
    strobes.rxTake  = hitData && !busWe && rxValid;
  end

  always_comb begin
    busRdata = '0;
    if (hitDiv) begin
      busRdata = divValue;
    end else if (hitData) begin
      busRdata = rxValid ? DATA_W'(rxByte) : '1;
    end
  end

endmodule

// File: rtl/uart_mm_datapath.sv
module uart_mm_datapath
  import uart_mm_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int BYTE_W   = 8,
  parameter int DIV_INIT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rxIn,
  output logic              txOut,
  output logic [DATA_W-1:0] divValue,
  output logic [BYTE_W-1:0] rxByte,
  output logic              rxValid,
  output logic              txBusy
);

  localparam int FRAME_W = BYTE_W + 2;
  localparam int BITS_W  = $clog2(FRAME_W + 1);
  localparam int IDX_W   = $clog2(BYTE_W);
  localparam logic [BITS_W-1:0] FRAME_CNT = BITS_W'(FRAME_W);
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(BYTE_W - 1);

  // Bit period
  logic [DATA_W-1:0] divReg;
  logic [DATA_W-1:0] effDiv;
  logic [DATA_W-1:0] halfDiv;

  always_ff @(posedge clk) begin
    if (!rstN) divReg <= DATA_W'(DIV_INIT);
    else if (strobes.divWe) divReg <= wdata;
  end

  assign effDiv   = (divReg == '0) ? DATA_W'(1) : divReg;
  assign halfDiv  = ((effDiv >> 1) == '0) ? DATA_W'(1) : (effDiv >> 1);
  assign divValue = divReg;

  // Transmitter
  logic [FRAME_W-1:0] txShift;
  logic [DATA_W-1:0]  txTimer;
  logic [BITS_W-1:0]  txBitsLeft;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift    <= '1;
      txTimer    <= '0;
      txBitsLeft <= '0;
    end else if (strobes.txStart) begin
      txShift    <= {1'b1, wdata[BYTE_W-1:0], 1'b0};
      txTimer    <= '0;
      txBitsLeft <= FRAME_CNT;
    end else if (txBitsLeft != '0) begin
      if (txTimer == effDiv - 1'b1) begin
        txTimer    <= '0;
        txShift    <= {1'b1, txShift[FRAME_W-1:1]};
        txBitsLeft <= txBitsLeft - 1'b1;
      end else begin
        txTimer <= txTimer + 1'b1;
      end
    end
  end

  assign txBusy = (txBitsLeft != '0);
  assign txOut  = txBusy ? txShift[0] : 1'b1;

  // Receiver
  logic [1:0]        rxSync;
  logic              rxLine;
  logic              rxPrev;
  rxState_e          rxState;
  logic [DATA_W-1:0] rxTimer;
  logic [IDX_W-1:0]  rxBitIdx;
  logic [BYTE_W-1:0] rxShift;
  logic              frameGood;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSync <= '1;
      rxPrev <= 1'b1;
    end else begin
      rxSync <= {rxSync[0], rxIn};
      rxPrev <= rxSync[1];
    end
  end

  assign rxLine    = rxSync[1];
  assign frameGood = (rxState == RX_STOP) && (rxTimer == effDiv - 1'b1) && rxLine;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState  <= RX_IDLE;
      rxTimer  <= '0;
      rxBitIdx <= '0;
      rxShift  <= '0;
    end else begin
      unique case (rxState)
        RX_IDLE: begin
          if (rxPrev && !rxLine) begin
            rxState <= RX_START;
            rxTimer <= '0;
          end
        end
        RX_START: begin
          if (rxTimer == halfDiv - 1'b1) begin
            rxTimer  <= '0;
            rxBitIdx <= '0;
            rxState  <= rxLine ? RX_IDLE : RX_DATA;
          end else begin
            rxTimer <= rxTimer + 1'b1;
          end
        end
        RX_DATA: begin
          if (rxTimer == effDiv - 1'b1) begin
            rxTimer <= '0;
            rxShift <= {rxLine, rxShift[BYTE_W-1:1]};
            if (rxBitIdx == LAST_IDX) rxState <= RX_STOP;
            else rxBitIdx <= rxBitIdx + 1'b1;
          end else begin
            rxTimer <= rxTimer + 1'b1;
          end
        end
        RX_STOP: begin
          if (rxTimer == effDiv - 1'b1) begin
            rxTimer <= '0;
            rxState <= RX_IDLE;
          end else begin
            rxTimer <= rxTimer + 1'b1;
          end
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxByte  <= '0;
      rxValid <= 1'b0;
    end else if (frameGood) begin
      rxByte  <= rxShift;
      rxValid <= 1'b1;
    end else if (strobes.rxTake) begin
      rxValid <= 1'b0;
    end
  end

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rstN)
    strobes.txStart |=> !txOut); // R3
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    strobes.txStart |-> !txBusy); // R5
  AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rxTake && !frameGood) |=> !rxValid); // R6
  AST_GOOD_STOP_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxValid) |-> $past(rxLine) && ($past(rxState) == RX_STOP)); // R9
  AST_DIV_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobes.divWe |=> divReg == $past(wdata)); // R2

endmodule

// File: rtl/uart_mm.sv
module uart_mm
  import uart_mm_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int DIV_INIT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busReady,
  input  logic              rxIn,
  output logic              txOut
);

  localparam int BYTE_W = 8;

  ctrlStrobes_t      strobes;
  logic [DATA_W-1:0] divValue;
  logic [BYTE_W-1:0] rxByte;
  logic              rxValid;
  logic              txBusy;

  uart_mm_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) ctrlInst (
    .busSel  (busSel),
    .busWe   (busWe),
    .busAddr (busAddr),
    .divValue(divValue),
    .rxByte  (rxByte),
    .rxValid (rxValid),
    .txBusy  (txBusy),
    .busReady(busReady),
    .busRdata(busRdata),
    .strobes (strobes)
  );

  uart_mm_datapath #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .DIV_INIT(DIV_INIT)) dpInst (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wdata   (busWdata),
    .rxIn    (rxIn),
    .txOut   (txOut),
    .divValue(divValue),
    .rxByte  (rxByte),
    .rxValid (rxValid),
    .txBusy  (txBusy)
  );

  AST_WRITE_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWe && busAddr == ADDR_W'(8) && txBusy) |-> !busReady); // R5
  AST_EMPTY_ALL_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWe && busAddr == ADDR_W'(8) && !rxValid) |-> busRdata == '1); // R7

endmodule

// File: tb/uart_mm_test.sv
module uart_mm_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWe = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busReady;
  logic        rxIn = 1'b1;
  logic        txOut;

  int nChecks = 0;
  int nFails  = 0;

  // 50 MHz: 20 time units per period
  always #10 clk = ~clk;

  uart_mm uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busReady(busReady),
    .rxIn(rxIn), .txOut(txOut)
  );

  // {bit period, tx byte, rx byte, rx stop bit}
  localparam logic [24:0] VECS [6] = '{
    {8'd6,  8'h55, 8'hA3, 1'b1},
    {8'd7,  8'h00, 8'hFF, 1'b1},
    {8'd8,  8'hFF, 8'h00, 1'b1},
    {8'd9,  8'h81, 8'h3C, 1'b0},
    {8'd12, 8'hC4, 8'h5A, 1'b1},
    {8'd6,  8'h01, 8'h80, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d, output int waits);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    #1;
    waits = 0;
    while (!busReady) begin
      waits++;
      @(negedge clk);
    end
    @(posedge clk);
    #1;
    busSel = 1'b0; busWe = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d, output logic rdy);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b0; busAddr = a;
    #1;
    d = busRdata;
    rdy = busReady;
    @(posedge clk);
    #1;
    busSel = 1'b0;
  endtask

  task automatic sendRx(input logic [7:0] b, input logic stopBit, input int div);
    logic [9:0] frame;
    frame = {stopBit, b, 1'b0};
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      rxIn = frame[i];
      repeat (div) @(negedge clk);
    end
    rxIn = 1'b1;
    repeat (div + 4) @(negedge clk);
  endtask

  task automatic captureTx(input int div, output logic [9:0] got);
    got = '0;
    for (int n = 0; n < 10 * div; n++) begin
      @(negedge clk);
      if (n % div == div / 2) got[n / div] = txOut;
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    logic        rdy;
    int          waits;
    logic [9:0]  frame;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // Reset state
    @(negedge clk);
    chk("R1 txOut idle", 32'(txOut), 32'h1);
    busRead(8'd4, rd, rdy);
    chk("R1 bit period reset", rd, 32'd16);
    busRead(8'd8, rd, rdy);
    chk("R1 data empty", rd, 32'hFFFF_FFFF);

    // Vector table
    foreach (VECS[i]) begin
      int          div;
      logic [7:0]  txB;
      logic [7:0]  rxB;
      logic        stopB;
      div   = int'(VECS[i][24:17]);
      txB   = VECS[i][16:9];
      rxB   = VECS[i][8:1];
      stopB = VECS[i][0];

      busWrite(8'd4, 32'hA500_0000 | 32'(div), waits);
      busRead(8'd4, rd, rdy);
      chk("R2 bit period readback", rd, 32'hA500_0000 | 32'(div));
      busWrite(8'd4, 32'(div), waits);

      busWrite(8'd8, {24'hDEAD_BE, txB}, waits);
      chk("R5 idle write ready", 32'(waits), 32'd0);
      captureTx(div, frame);
      chk("R3 tx frame", 32'(frame), 32'({1'b1, txB, 1'b0}));
      @(negedge clk);
      chk("R4 tx idle high", 32'(txOut), 32'h1);

      sendRx(rxB, stopB, div);
      busRead(8'd8, rd, rdy);
      if (stopB) chk("R6 rx byte", rd, 32'(rxB));
      else       chk("R9 bad stop dropped", rd, 32'hFFFF_FFFF);
      busRead(8'd8, rd, rdy);
      chk("R7 empty after read", rd, 32'hFFFF_FFFF);
    end

    // Stall: bit period is 6 here
    busWrite(8'd8, 32'h3A, waits);
    busRead(8'd4, rd, rdy);
    chk("R5 read ready while busy", 32'(rdy), 32'h1);
    busWrite(8'd8, 32'h5C, waits);
    chk("R5 stall length", 32'(waits), 32'd59);
    captureTx(6, frame);
    chk("R3 stalled byte sent", 32'(frame), 32'({1'b1, 8'h5C, 1'b0}));

    // Overwrite
    sendRx(8'h11, 1'b1, 6);
    sendRx(8'h7E, 1'b1, 6);
    busRead(8'd8, rd, rdy);
    chk("R10 newest byte kept", rd, 32'h7E);

    // Bad stop keeps held byte
    sendRx(8'h42, 1'b1, 6);
    sendRx(8'h99, 1'b0, 6);
    busRead(8'd8, rd, rdy);
    chk("R9 held byte kept", rd, 32'h42);

    // Glitch shorter than half a bit, bit period 8
    busWrite(8'd4, 32'd8, waits);
    @(negedge clk);
    rxIn = 1'b0;
    @(negedge clk);
    rxIn = 1'b1;
    repeat (100) @(negedge clk);
    busRead(8'd8, rd, rdy);
    chk("R11 glitch ignored", rd, 32'hFFFF_FFFF);

    // Frame after glitch still received (sync + edge detect)
    sendRx(8'hB6, 1'b1, 8);
    busRead(8'd8, rd, rdy);
    chk("R8 frame after glitch", rd, 32'hB6);

    finishRun();
  end

endmodule